// File: doc/BRIEF.md
# Snoop Write-Back Bus Sequencer

This block runs the external side of a burst bus master that must yield to an outside snooper. It issues three kinds of transfer: four-beat line fills, four-beat write-backs of dirty lines, and single-beat posted writes. Each transfer starts with a one-clock address strobe and ends when the slave returns burst-ready together with last-transfer. Write misses go into a small FIFO and wait there while the bus is held. A small direct-mapped table records which lines are modified, so a snoop can be matched against it.

When a snoop hits a modified line during a line fill, the snooper aborts the fill with back-off and holds the bus with address hold. The block then signals hit-modified and keeps it asserted while it waits. Once both holds are released, it writes the dirty line back. It then reissues the aborted fill from its first beat and releases hit-modified in the same clock as the restart strobe.

Top module: `snoop_wb_seq`

## Requirements
- R1: During reset and in the first clock after it, `ads_n` and `hitm_n` are high, and `wr_full` and `fill_done` are low.
- R2: No address strobe is issued in a clock that follows an edge where `ahold` was sampled high. With the bus idle, work pending and `boff_n` high, `ads_n` goes low in the clock after the first edge at which `ahold` is sampled low.
- R3: A write request is accepted while the buffer holds fewer than `WB_DEPTH` (4) entries. `wr_full` is high at 4 entries, and a request made while it is high is dropped. Entries leave in FIFO order as single-beat writes: `ads_n` low, `wnr` high, the entry's address on `bus_addr` and its data on `bus_wdata`. Each write ends on a clock where `brdy_n` and `blast_n` are both low.
- R4: A line transfer strobes `bus_addr` = line × 4, with the two low bits zero, for exactly one clock. It ends on the clock where `brdy_n` and `blast_n` are both sampled low. For a fill, `fill_done` is high for the one following clock.
- R5: `mark_mod` with `mark_line` marks that line as modified. A `snp_stb` whose `snp_line` matches a marked line drives `hitm_n` low in the next clock. A snoop of an unmarked line, or of a line that shares the table slot but has a different tag, leaves `hitm_n` high.
- R6: `boff_n` sampled low during the address or data phase ends the transfer at once and drops the beats already received. No strobe is issued in the clock after any edge where `boff_n` is low. Once `boff_n` is high again, the aborted transfer is reissued from its first address.
- R7: After a snoop hit, the first transfer is the write-back: `wnr` high and `bus_addr` = snoop line × 4. Its strobe comes in the clock after the first edge at which both `ahold` is low and `boff_n` is high.
- R8: If an aborted fill is waiting, `hitm_n` rises in the same clock as that fill's restart strobe, which has `wnr` low and carries the fill's address. Otherwise `hitm_n` rises in the clock after the write-back's last beat. In both cases the line's modified mark is cleared, so a repeated snoop of that line leaves `hitm_n` high.
- R9: A fresh fill that has never been issued waits until all buffered writes have drained. An aborted fill is restarted ahead of buffered writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ahold | input | 1 | Address hold from the snooper; blocks new transfers |
| boff_n | input | 1 | Back-off, active low; aborts the current transfer |
| snp_stb | input | 1 | Snoop strobe |
| snp_line | input | AW-2 | Line address being snooped |
| brdy_n | input | 1 | Burst ready, active low, one per beat |
| blast_n | input | 1 | Last transfer, active low |
| mark_mod | input | 1 | Mark a line as modified |
| mark_line | input | AW-2 | Line address to mark |
| rd_req | input | 1 | Read-miss request for a line fill |
| rd_line | input | AW-2 | Line address to fill |
| wr_req | input | 1 | Write-miss request to post |
| wr_addr | input | AW | Word address of the posted write |
| wr_data | input | DW | Data of the posted write |
| wr_full | output | 1 | Write buffer full |
| ads_n | output | 1 | Address strobe, active low |
| wnr | output | 1 | Direction: 1 write, 0 read |
| hitm_n | output | 1 | Hit on a modified line, active low |
| bus_addr | output | AW | Bus word address |
| bus_wdata | output | DW | Data of a posted write |
| fill_done | output | 1 | One-clock pulse when a line fill completes |

## Verification
All outputs come from registers. A strobe appears one clock after the edge that first sees idle, `ahold` low and `boff_n` high. `hitm_n` falls one clock after the snoop edge. `fill_done` and a released `hitm_n` appear one clock after the last-beat edge. The bench drives inputs on falling edges and reads each output at the falling edge right after the rising edge where the result is due. It pins exact clocks where timing is itself the requirement (hold release, back-off release, restart with release) and polls for a strobe only where just its order and contents matter.

// File: rtl/snoop_wb_pkg.sv
// Package: shared types for the snoop write-back sequencer.
// Assumes a line is four bus words.
package snoop_wb_pkg;
    localparam int unsigned LINE_OFFW = 2;

    typedef enum logic [1:0] {
        BS_IDLE = 2'd0,
        BS_ADDR = 2'd1,
        BS_DATA = 2'd2
    } bus_state_t;

    typedef enum logic [1:0] {
        XK_WBACK = 2'd0,
        XK_FILL  = 2'd1,
        XK_POST  = 2'd2
    } xfer_kind_t;
endpackage

// File: rtl/snoop_line_table.sv
// Direct-mapped table of modified lines. One set port, one clear port,
// one lookup port. Assumes LINES is a power of two below 2**LW.
module snoop_line_table #(
    parameter int unsigned LW    = 14,
    parameter int unsigned LINES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_en,
    input  logic [LW-1:0] set_line,
    input  logic          clr_en,
    input  logic [LW-1:0] clr_line,
    input  logic [LW-1:0] look_line,
    output logic          look_mod
);
    localparam int unsigned IDXW = $clog2(LINES);
    localparam int unsigned TW   = LW - IDXW;

    logic [LINES-1:0] mod_q;
    logic [TW-1:0]    tag_q [LINES];

    // Update each slot's modified flag and tag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mod_q <= '0;
            for (int e = 0; e < LINES; e++) tag_q[e] <= '0;
        end else begin
            for (int e = 0; e < LINES; e++) begin
                if (set_en && set_line[IDXW-1:0] == IDXW'(e)) begin
                    mod_q[e] <= 1'b1;
                    tag_q[e] <= set_line[LW-1:IDXW];
                end else if (clr_en && clr_line[IDXW-1:0] == IDXW'(e)
                             && tag_q[e] == clr_line[LW-1:IDXW]) begin
                    mod_q[e] <= 1'b0;
                end
            end
        end
    end

    // Lookup: a hit needs the slot marked and the tag equal.
    always_comb begin
        look_mod = mod_q[look_line[IDXW-1:0]]
                   && (tag_q[look_line[IDXW-1:0]] == look_line[LW-1:IDXW]);
    end
endmodule

// File: rtl/snoop_post_fifo.sv
// FIFO holding posted writes (address and data). Push is ignored when
// full, pop when empty. Assumes DEPTH is a power of two.
module snoop_post_fifo #(
    parameter int unsigned AW    = 16,
    parameter int unsigned DW    = 32,
    parameter int unsigned DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [AW-1:0]                push_addr,
    input  logic [DW-1:0]                push_data,
    input  logic                         pop,
    output logic [AW-1:0]                head_addr,
    output logic [DW-1:0]                head_data,
    output logic                         empty,
    output logic                         full,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int unsigned PW = $clog2(DEPTH);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic [AW-1:0] addr_mem [DEPTH];
    logic [DW-1:0] data_mem [DEPTH];
    logic [PW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;
    logic          do_push, do_pop;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign count   = cnt_q;
    assign head_addr = addr_mem[rp_q];
    assign head_data = data_mem[rp_q];

    // Store the pushed entry at the write pointer.
    always_ff @(posedge clk) begin
        if (do_push) begin
            addr_mem[wp_q] <= push_addr;
            data_mem[wp_q] <= push_data;
        end
    end

    // Move the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wp_q <= wp_q + 1'b1;
            if (do_pop)  rp_q <= rp_q + 1'b1;
            cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
        end
    end
endmodule

// File: rtl/snoop_wb_seq.sv
// Bus sequencer for line fills, dirty-line write-backs and posted writes,
// under snoop control. Outputs are registered. Assumes the snooper keeps
// at most one write-back outstanding, and that a fill request comes only
// while no fill is pending.
module snoop_wb_seq #(
    parameter int unsigned AW       = 16,
    parameter int unsigned DW       = 32,
    parameter int unsigned LINES    = 4,
    parameter int unsigned WB_DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ahold,
    input  logic                         boff_n,
    input  logic                         snp_stb,
    input  logic [AW-snoop_wb_pkg::LINE_OFFW-1:0] snp_line,
    input  logic                         brdy_n,
    input  logic                         blast_n,
    input  logic                         mark_mod,
    input  logic [AW-snoop_wb_pkg::LINE_OFFW-1:0] mark_line,
    input  logic                         rd_req,
    input  logic [AW-snoop_wb_pkg::LINE_OFFW-1:0] rd_line,
    input  logic                         wr_req,
    input  logic [AW-1:0]                wr_addr,
    input  logic [DW-1:0]                wr_data,
    output logic                         wr_full,
    output logic                         ads_n,
    output logic                         wnr,
    output logic                         hitm_n,
    output logic [AW-1:0]                bus_addr,
    output logic [DW-1:0]                bus_wdata,
    output logic                         fill_done
);
    import snoop_wb_pkg::*;

    localparam int unsigned LW = AW - LINE_OFFW;
    localparam int unsigned CW = $clog2(WB_DEPTH + 1);

    bus_state_t st_q;
    xfer_kind_t kind_q, pick;
    logic          have_work, launch, last_beat;
    logic          wb_pend_q, fill_pend_q, fill_tried_q;
    logic [LW-1:0] wb_line_q, fill_line_q;
    logic          hitm_q, ads_q, wnr_q, done_q;
    logic [AW-1:0] addr_q, pick_addr;
    logic [DW-1:0] wdata_q;
    logic          snp_mod, snp_hit;
    logic          buf_empty, buf_full, buf_pop;
    logic [AW-1:0] buf_addr;
    logic [DW-1:0] buf_data;
    logic [CW-1:0] buf_cnt;

    snoop_line_table #(.LW(LW), .LINES(LINES)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (mark_mod),
        .set_line (mark_line),
        .clr_en   (last_beat && kind_q == XK_WBACK),
        .clr_line (wb_line_q),
        .look_line(snp_line),
        .look_mod (snp_mod)
    );

    snoop_post_fifo #(.AW(AW), .DW(DW), .DEPTH(WB_DEPTH)) u_post (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (wr_req),
        .push_addr(wr_addr),
        .push_data(wr_data),
        .pop      (buf_pop),
        .head_addr(buf_addr),
        .head_data(buf_data),
        .empty    (buf_empty),
        .full     (buf_full),
        .count    (buf_cnt)
    );

    assign snp_hit   = snp_stb && snp_mod && !wb_pend_q;
    assign last_beat = (st_q == BS_DATA) && boff_n && !brdy_n && !blast_n;
    assign buf_pop   = last_beat && kind_q == XK_POST;
    assign launch    = (st_q == BS_IDLE) && !ahold && boff_n && have_work;

    // Pick the next transfer: write-back, restart, posted write, fresh fill.
    always_comb begin
        have_work = 1'b1;
        pick      = XK_FILL;
        if (wb_pend_q)                        pick = XK_WBACK;
        else if (fill_pend_q && fill_tried_q) pick = XK_FILL;
        else if (!buf_empty)                  pick = XK_POST;
        else if (!fill_pend_q)                have_work = 1'b0;
    end

    // Address of the picked transfer.
    always_comb begin
        case (pick)
            XK_WBACK: pick_addr = {wb_line_q, {LINE_OFFW{1'b0}}};
            XK_POST:  pick_addr = buf_addr;
            default:  pick_addr = {fill_line_q, {LINE_OFFW{1'b0}}};
        endcase
    end

    // Bus phase machine, pending work and hit-modified control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= BS_IDLE;
            kind_q       <= XK_FILL;
            wb_pend_q    <= 1'b0;
            wb_line_q    <= '0;
            fill_pend_q  <= 1'b0;
            fill_tried_q <= 1'b0;
            fill_line_q  <= '0;
            hitm_q       <= 1'b1;
            ads_q        <= 1'b1;
            wnr_q        <= 1'b0;
            addr_q       <= '0;
            wdata_q      <= '0;
            done_q       <= 1'b0;
        end else begin
            done_q <= last_beat && kind_q == XK_FILL;
            case (st_q)
                BS_IDLE: begin
                    if (launch) begin
                        st_q    <= BS_ADDR;
                        kind_q  <= pick;
                        ads_q   <= 1'b0;
                        wnr_q   <= (pick != XK_FILL);
                        addr_q  <= pick_addr;
                        wdata_q <= buf_data;
                        if (pick == XK_FILL) begin
                            fill_tried_q <= 1'b1;
                            hitm_q       <= 1'b1;
                        end
                    end
                end
                BS_ADDR: begin
                    ads_q <= 1'b1;
                    st_q  <= boff_n ? BS_DATA : BS_IDLE;
                end
                default: begin
                    if (!boff_n) begin
                        st_q <= BS_IDLE;
                    end else if (last_beat) begin
                        st_q <= BS_IDLE;
                        if (kind_q == XK_WBACK) begin
                            wb_pend_q <= 1'b0;
                            if (!(fill_pend_q && fill_tried_q)) hitm_q <= 1'b1;
                        end else if (kind_q == XK_FILL) begin
                            fill_pend_q  <= 1'b0;
                            fill_tried_q <= 1'b0;
                        end
                    end
                end
            endcase
            if (rd_req && !fill_pend_q) begin
                fill_pend_q <= 1'b1;
                fill_line_q <= rd_line;
            end
            if (snp_hit) begin
                wb_pend_q <= 1'b1;
                wb_line_q <= snp_line;
                hitm_q    <= 1'b0;
            end
        end
    end

    assign wr_full   = buf_full;
    assign ads_n     = ads_q;
    assign wnr       = wnr_q;
    assign hitm_n    = hitm_q;
    assign bus_addr  = addr_q;
    assign bus_wdata = wdata_q;
    assign fill_done = done_q;
endmodule

// File: rtl/snoop_wb_seq_chk.sv
// Checker for snoop_wb_seq, attached by bind. Watches the ports and the
// write-buffer occupancy.
module snoop_wb_seq_chk #(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned CW    = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ahold,
    input logic          boff_n,
    input logic          snp_stb,
    input logic          brdy_n,
    input logic          blast_n,
    input logic          ads_n,
    input logic          wnr,
    input logic          hitm_n,
    input logic          fill_done,
    input logic [CW-1:0] buf_cnt
);
    assert_no_ads_in_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ads_n) |-> (!$past(ahold) && $past(boff_n)));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        buf_cnt <= CW'(DEPTH));

    assert_single_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ads_n |=> ads_n);

    assert_done_on_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |-> $past(!brdy_n && !blast_n));

    assert_hitm_after_snoop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hitm_n) |-> $past(snp_stb));

    assert_quiet_in_backoff_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !boff_n |=> ads_n);

    assert_hitm_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hitm_n) |-> ((!ads_n && !wnr) || $past(!brdy_n && !blast_n)));
endmodule

bind snoop_wb_seq snoop_wb_seq_chk #(.DEPTH(WB_DEPTH), .CW($clog2(WB_DEPTH + 1))) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ahold    (ahold),
    .boff_n   (boff_n),
    .snp_stb  (snp_stb),
    .brdy_n   (brdy_n),
    .blast_n  (blast_n),
    .ads_n    (ads_n),
    .wnr      (wnr),
    .hitm_n   (hitm_n),
    .fill_done(fill_done),
    .buf_cnt  (buf_cnt)
);

// File: tb/test_snoop_wb_seq.sv
// Self-checking bench: drives on falling edges, samples on falling edges.
module test_snoop_wb_seq;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int LW = AW - 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ahold = 1'b0, boff_n = 1'b1, snp_stb = 1'b0;
    logic [LW-1:0] snp_line = '0, mark_line = '0, rd_line = '0;
    logic brdy_n = 1'b1, blast_n = 1'b1, mark_mod = 1'b0, rd_req = 1'b0, wr_req = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic wr_full, ads_n, wnr, hitm_n, fill_done;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    snoop_wb_seq #(.AW(AW), .DW(DW), .LINES(4), .WB_DEPTH(4)) i_snoop_wb_seq (
        .clk(clk), .rst_n(rst_n), .ahold(ahold), .boff_n(boff_n),
        .snp_stb(snp_stb), .snp_line(snp_line), .brdy_n(brdy_n), .blast_n(blast_n),
        .mark_mod(mark_mod), .mark_line(mark_line), .rd_req(rd_req), .rd_line(rd_line),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_full(wr_full),
        .ads_n(ads_n), .wnr(wnr), .hitm_n(hitm_n), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .fill_done(fill_done)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_ads(input string req, input logic exp_wnr,
                            input logic [AW-1:0] exp_addr, input logic [DW-1:0] exp_data,
                            input bit chk_data);
        int k = 0;
        while (ads_n !== 1'b0 && k < 60) begin
            tick();
            k++;
        end
        chk({req, " strobe seen"}, 32'(ads_n), 32'h0);
        chk({req, " direction"}, 32'(wnr), 32'(exp_wnr));
        chk({req, " address"}, 32'(bus_addr), 32'(exp_addr));
        if (chk_data) chk({req, " data"}, bus_wdata, exp_data);
    endtask

    task automatic serve(input int beats);
        tick();
        for (int i = 1; i <= beats; i++) begin
            brdy_n  = 1'b0;
            blast_n = (i == beats) ? 1'b0 : 1'b1;
            tick();
        end
        brdy_n  = 1'b1;
        blast_n = 1'b1;
    endtask

    task automatic push_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        wr_req = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_req = 1'b0;
    endtask

    task automatic snoop(input logic [LW-1:0] l);
        snp_stb = 1'b1; snp_line = l;
        tick();
        snp_stb = 1'b0;
    endtask

    task automatic mark(input logic [LW-1:0] l);
        mark_mod = 1'b1; mark_line = l;
        tick();
        mark_mod = 1'b0;
    endtask

    task automatic request_fill(input logic [LW-1:0] l);
        rd_req = 1'b1; rd_line = l;
        tick();
        rd_req = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) tick();
        chk("R1 ads_n", 32'(ads_n), 32'h1);
        chk("R1 hitm_n", 32'(hitm_n), 32'h1);
        chk("R1 wr_full", 32'(wr_full), 32'h0);
        chk("R1 fill_done", 32'(fill_done), 32'h0);
        rst_n = 1'b1;
        tick();
        chk("R1 ads_n after release", 32'(ads_n), 32'h1);

        // R4 plain line fill
        request_fill(14'h0048);
        wait_ads("R4 fill", 1'b0, 16'h0120, '0, 1'b0);
        serve(4);
        chk("R4 fill_done pulse", 32'(fill_done), 32'h1);
        tick();
        chk("R4 fill_done one clock", 32'(fill_done), 32'h0);

        // R2 R3 posting sweep over 1..4 entries, plus one dropped on full
        for (int n = 1; n <= 4; n++) begin
            ahold = 1'b1;
            tick();
            for (int i = 0; i < n; i++)
                push_wr(16'(16'h1000 + 16 * n + i), 32'(32'hA000 + 256 * n + i));
            chk("R3 wr_full at count", 32'(wr_full), 32'(n == 4));
            if (n == 4) push_wr(16'h1FFF, 32'hDEAD);
            for (int w = 0; w < 3; w++) begin
                tick();
                chk("R2 no strobe under hold", 32'(ads_n), 32'h1);
            end
            ahold = 1'b0;
            tick();
            chk("R2 strobe one clock after hold drop", 32'(ads_n), 32'h0);
            for (int i = 0; i < n; i++) begin
                wait_ads("R3 drain", 1'b1, 16'(16'h1000 + 16 * n + i),
                         32'(32'hA000 + 256 * n + i), 1'b1);
                serve(1);
            end
            for (int w = 0; w < 4; w++) begin
                tick();
                chk("R3 nothing left after drain", 32'(ads_n), 32'h1);
            end
        end

        // R9 fresh fill waits for posted writes
        ahold = 1'b1;
        tick();
        push_wr(16'h2000, 32'h11);
        push_wr(16'h2001, 32'h22);
        request_fill(14'h0080);
        ahold = 1'b0;
        wait_ads("R9 first write", 1'b1, 16'h2000, 32'h11, 1'b1);
        serve(1);
        wait_ads("R9 second write", 1'b1, 16'h2001, 32'h22, 1'b1);
        serve(1);
        wait_ads("R9 fill last", 1'b0, 16'h0200, '0, 1'b0);
        serve(4);
        chk("R9 fill done", 32'(fill_done), 32'h1);

        // R5 R7 R8 snoop sweep over every table slot, no fill pending
        for (int idx = 0; idx < 4; idx++) begin
            mark(14'((8'h30 + idx) * 4 + idx));
            snoop(14'((8'h50 + idx) * 4 + idx));
            chk("R5 other tag no hit", 32'(hitm_n), 32'h1);
            tick();
            chk("R5 other tag still quiet", 32'(hitm_n), 32'h1);
            snoop(14'((8'h30 + idx) * 4 + idx));
            chk("R5 hit drives hitm low", 32'(hitm_n), 32'h0);
            wait_ads("R7 write-back", 1'b1, 16'(((8'h30 + idx) * 4 + idx) * 4), '0, 1'b0);
            serve(4);
            chk("R8 release after write-back", 32'(hitm_n), 32'h1);
            snoop(14'((8'h30 + idx) * 4 + idx));
            chk("R8 mark cleared", 32'(hitm_n), 32'h1);
            tick();
        end

        // R6 R7 R8 R9 aborted fill, write-back, restart ahead of posted write
        mark(14'h0110);
        request_fill(14'h0140);
        wait_ads("R6 first fill", 1'b0, 16'h0500, '0, 1'b0);
        tick();
        brdy_n = 1'b0;
        tick();
        tick();
        brdy_n = 1'b1; boff_n = 1'b0; ahold = 1'b1;
        snp_stb = 1'b1; snp_line = 14'h0110;
        wr_req = 1'b1; wr_addr = 16'h0777; wr_data = 32'h55;
        tick();
        snp_stb = 1'b0; wr_req = 1'b0;
        chk("R5 hit during fill", 32'(hitm_n), 32'h0);
        for (int w = 0; w < 3; w++) begin
            tick();
            chk("R6 quiet in back-off", 32'(ads_n), 32'h1);
        end
        ahold = 1'b0;
        tick();
        chk("R6 back-off still blocks", 32'(ads_n), 32'h1);
        boff_n = 1'b1;
        tick();
        chk("R7 write-back one clock after back-off", 32'(ads_n), 32'h0);
        chk("R7 write-back direction", 32'(wnr), 32'h1);
        chk("R7 write-back address", 32'(bus_addr), 32'h0440);
        serve(4);
        chk("R8 held until restart", 32'(hitm_n), 32'h0);
        chk("R6 no done for aborted fill", 32'(fill_done), 32'h0);
        tick();
        chk("R6 restart strobe", 32'(ads_n), 32'h0);
        chk("R6 restart read", 32'(wnr), 32'h0);
        chk("R6 restart address", 32'(bus_addr), 32'h0500);
        chk("R8 release with restart", 32'(hitm_n), 32'h1);
        serve(4);
        chk("R6 restarted fill done", 32'(fill_done), 32'h1);
        wait_ads("R9 posted write after restart", 1'b1, 16'h0777, 32'h55, 1'b1);
        serve(1);
        repeat (3) tick();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule